// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each 32-bit virtual address into one of four regions of the address space and reports the access attributes that follow from that region. The top address bits select the region. Bit 31 clear gives the user region, which is 2 GB and translated. The kernel has three windows. Two of them are 512 MB direct windows onto the low 512 MB of physical memory, one cached and one uncached. The third is a 1 GB translated kernel window. The privilege input decides whether the kernel windows may be reached.

For the two direct windows the decoder produces the 29-bit physical address at once. For the two translated regions it hands the 20-bit page number and 12-bit page offset to a downstream translation lookaside buffer (TLB). A user-mode access above 2 GB raises an address error and selects no region. With the default setting the result is held in an output register, so it appears one clock after the address is presented.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is sampled high, every output is 0, whatever the inputs are.
- R2: When `acc_valid` is 0, every output is 0, including `addr_err`.
- R3: An address with bit 31 clear selects the user region in either mode: `seg_sel` = 4'b0001, `tlb_req` = 1, `vpn` = addr[31:12], `page_off` = addr[11:0], `cacheable` = 0, `phys_valid` = 0.
- R4: In kernel mode (`kernel_mode` = 1), addr[31:29] = 3'b100 selects the cached direct window: `seg_sel` = 4'b0010, `cacheable` = 1, `phys_valid` = 1, `phys_addr` = addr[28:0], `tlb_req` = 0.
- R5: In kernel mode, addr[31:29] = 3'b101 selects the uncached direct window: `seg_sel` = 4'b0100, `cacheable` = 0, `phys_valid` = 1, `phys_addr` = addr[28:0], `tlb_req` = 0.
- R6: In kernel mode, addr[31:30] = 2'b11 selects the translated kernel window: `seg_sel` = 4'b1000, `tlb_req` = 1, `vpn` and `page_off` as in R3, `cacheable` = 0, `phys_valid` = 0.
- R7: In user mode (`kernel_mode` = 0), a valid access with bit 31 set gives `addr_err` = 1, `seg_sel` = 0 and `legal` = 0. `tlb_req`, `phys_valid`, `cacheable`, `phys_addr`, `vpn` and `page_off` are all 0.
- R8: With `REG_OUT` = 1, the outputs show the decode of the inputs sampled at the previous rising edge and hold it until the next edge.
- R9: `seg_sel` has at most one bit set. `legal` is 1 exactly when a region is selected, and `legal` and `addr_err` are never both 1. `phys_addr` is 0 unless `phys_valid` is 1, and `vpn` and `page_off` are 0 unless `tlb_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe; when low, all results are forced to 0 |
| kernel_mode | input | 1 | 1 = kernel privilege, 0 = user |
| vaddr | input | 32 | Virtual address |
| seg_sel | output | 4 | One-hot region: bit3 kernel translated, bit2 uncached direct, bit1 cached direct, bit0 user |
| legal | output | 1 | Access permitted in the current mode |
| addr_err | output | 1 | User access above 2 GB |
| cacheable | output | 1 | Cached direct window selected |
| tlb_req | output | 1 | Region needs TLB translation |
| phys_valid | output | 1 | `phys_addr` carries a direct physical address |
| phys_addr | output | 29 | Direct physical address |
| vpn | output | 20 | Virtual page number for the TLB |
| page_off | output | 12 | Page offset for the TLB |

## Verification
Two functions can act on the same access. The privilege check rejects a user access above 2 GB, and the region decode would otherwise select a direct window or the translated kernel window from the same top bits. The bench drives every region boundary address in both modes. For a user access at 0x80000000, 0xA0000000 or 0xC0000000 it requires `addr_err` together with a silent `seg_sel`, `tlb_req` and `phys_valid`. For the same address in kernel mode it requires the full decode. A second case pairs reset with a valid kernel access, and the bench judges that reset wins by reading all-zero outputs at the next sample.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W     = 32;
  localparam int PG_BITS  = 12;
  localparam int VPN_W    = VA_W - PG_BITS;
  localparam int WIN_BITS = 3;
  localparam int DIR_W    = VA_W - WIN_BITS;
  localparam int NSEG     = 4;

  typedef enum logic [1:0] {
    SEG_USER = 2'd0,
    SEG_KDC  = 2'd1,
    SEG_KDU  = 2'd2,
    SEG_KMAP = 2'd3
  } seg_e;

  typedef struct packed {
    logic [NSEG-1:0]  seg;
    logic             legal;
    logic             err;
    logic             cache;
    logic             tlb;
    logic             pv;
    logic [DIR_W-1:0] phys;
    logic [VPN_W-1:0] vpn;
    logic [PG_BITS-1:0] off;
  } vseg_res_t;
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
(
  input  logic                acc_valid,
  input  logic                kernel_mode,
  input  logic [WIN_BITS-1:0] top_bits,
  output logic [NSEG-1:0]     seg,
  output logic                err
);
  always_comb begin
    seg = '0;
    err = 1'b0;
    if (acc_valid) begin
      if (!top_bits[WIN_BITS-1]) begin
        seg[SEG_USER] = 1'b1;
      end else if (!kernel_mode) begin
        err = 1'b1;
      end else begin
        case (top_bits[WIN_BITS-2:WIN_BITS-3])
          2'b00:   seg[SEG_KDC]  = 1'b1;
          2'b01:   seg[SEG_KDU]  = 1'b1;
          default: seg[SEG_KMAP] = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/vseg_attr.sv
module vseg_attr
  import vseg_pkg::*;
(
  input  logic [NSEG-1:0] seg,
  input  logic            err,
  input  logic [VA_W-1:0] vaddr,
  output vseg_res_t       res
);
  logic direct, mapped;

  always_comb begin
    direct    = seg[SEG_KDC] | seg[SEG_KDU];
    mapped    = seg[SEG_USER] | seg[SEG_KMAP];
    res.seg   = seg;
    res.legal = |seg;
    res.err   = err;
    res.cache = seg[SEG_KDC];
    res.tlb   = mapped;
    res.pv    = direct;
    res.phys  = direct ? vaddr[DIR_W-1:0] : '0;
    res.vpn   = mapped ? vaddr[VA_W-1:PG_BITS] : '0;
    res.off   = mapped ? vaddr[PG_BITS-1:0] : '0;
  end
endmodule

// File: rtl/vseg_outreg.sv
module vseg_outreg
  import vseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  vseg_res_t d,
  output vseg_res_t q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_pass
      always_comb q = rst ? '0 : d;
    end
  endgenerate
endmodule

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder
  import vseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic                 kernel_mode,
  input  logic [VA_W-1:0]      vaddr,
  output logic [NSEG-1:0]      seg_sel,
  output logic                 legal,
  output logic                 addr_err,
  output logic                 cacheable,
  output logic                 tlb_req,
  output logic                 phys_valid,
  output logic [DIR_W-1:0]     phys_addr,
  output logic [VPN_W-1:0]     vpn,
  output logic [PG_BITS-1:0]   page_off
);
  logic [NSEG-1:0] seg_c;
  logic            err_c;
  vseg_res_t       res_c, res_q;

  vseg_classify u_cls (
    .acc_valid   (acc_valid),
    .kernel_mode (kernel_mode),
    .top_bits    (vaddr[VA_W-1:VA_W-WIN_BITS]),
    .seg         (seg_c),
    .err         (err_c)
  );

  vseg_attr u_attr (
    .seg   (seg_c),
    .err   (err_c),
    .vaddr (vaddr),
    .res   (res_c)
  );

  vseg_outreg #(.REG_OUT(REG_OUT)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (res_c),
    .q   (res_q)
  );

  assign seg_sel    = res_q.seg;
  assign legal      = res_q.legal;
  assign addr_err   = res_q.err;
  assign cacheable  = res_q.cache;
  assign tlb_req    = res_q.tlb;
  assign phys_valid = res_q.pv;
  assign phys_addr  = res_q.phys;
  assign vpn        = res_q.vpn;
  assign page_off   = res_q.off;
endmodule

// File: rtl/vseg_checker.sv
module vseg_checker
  import vseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic                kernel_mode,
  input logic [VA_W-1:0]     vaddr,
  input logic [NSEG-1:0]     seg_sel,
  input logic                legal,
  input logic                addr_err,
  input logic                cacheable,
  input logic                tlb_req,
  input logic                phys_valid,
  input logic [DIR_W-1:0]    phys_addr,
  input logic [VPN_W-1:0]    vpn,
  input logic [PG_BITS-1:0]  page_off
);
  logic            st_live, st_valid, st_kern;
  logic [VA_W-1:0] st_addr;

  generate
    if (REG_OUT) begin : g_stage
      always_ff @(posedge clk) begin
        st_live  <= !rst;
        st_valid <= acc_valid;
        st_kern  <= kernel_mode;
        st_addr  <= vaddr;
      end
      // R1: the edge after reset is sampled leaves every output cleared
      assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (seg_sel == '0 && !legal && !addr_err && !cacheable &&
                 !tlb_req && !phys_valid && phys_addr == '0 &&
                 vpn == '0 && page_off == '0));
    end else begin : g_comb
      always_comb begin
        st_live  = !rst;
        st_valid = acc_valid;
        st_kern  = kernel_mode;
        st_addr  = vaddr;
      end
    end
  endgenerate

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (st_live && !st_valid) |->
      (seg_sel == '0 && !legal && !addr_err && !cacheable && !tlb_req && !phys_valid));

  assert_user_region_R3: assert property (@(posedge clk) disable iff (rst)
    (st_live && st_valid && !st_addr[VA_W-1]) |->
      (seg_sel == 4'b0001 && tlb_req && vpn == st_addr[VA_W-1:PG_BITS] &&
       page_off == st_addr[PG_BITS-1:0] && !phys_valid));

  assert_cached_direct_R4: assert property (@(posedge clk) disable iff (rst)
    (st_live && st_valid && st_kern && st_addr[VA_W-1:VA_W-3] == 3'b100) |->
      (seg_sel == 4'b0010 && cacheable && phys_valid &&
       phys_addr == st_addr[DIR_W-1:0] && !tlb_req));

  assert_uncached_direct_R5: assert property (@(posedge clk) disable iff (rst)
    (st_live && st_valid && st_kern && st_addr[VA_W-1:VA_W-3] == 3'b101) |->
      (seg_sel == 4'b0100 && !cacheable && phys_valid &&
       phys_addr == st_addr[DIR_W-1:0] && !tlb_req));

  assert_kernel_mapped_R6: assert property (@(posedge clk) disable iff (rst)
    (st_live && st_valid && st_kern && st_addr[VA_W-1:VA_W-2] == 2'b11) |->
      (seg_sel == 4'b1000 && tlb_req && !cacheable && !phys_valid &&
       vpn == st_addr[VA_W-1:PG_BITS]));

  assert_user_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (st_live && st_valid && !st_kern && st_addr[VA_W-1]) |->
      (addr_err && seg_sel == '0 && !legal && !tlb_req && !phys_valid && !cacheable));

  assert_consistent_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg_sel) && (legal == (seg_sel != '0)) && !(legal && addr_err) &&
    (phys_valid || phys_addr == '0) && (tlb_req || (vpn == '0 && page_off == '0)));
endmodule

bind vaddr_seg_decoder vseg_checker #(.REG_OUT(REG_OUT)) u_vseg_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .kernel_mode (kernel_mode),
  .vaddr       (vaddr),
  .seg_sel     (seg_sel),
  .legal       (legal),
  .addr_err    (addr_err),
  .cacheable   (cacheable),
  .tlb_req     (tlb_req),
  .phys_valid  (phys_valid),
  .phys_addr   (phys_addr),
  .vpn         (vpn),
  .page_off    (page_off)
);

// File: tb/test_vaddr_seg_decoder.sv
module test_vaddr_seg_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;
  localparam int VW = 42;

  // vector: {valid, kern, addr[31:0], seg[3:0], err, cache, tlb, pv}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b1, 32'h7FFF_FFFF, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 32'h8000_0000, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'h9FFF_FFFF, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'hA000_0000, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'hBFFF_FFFF, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'hC000_0000, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 32'h0000_0000, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 32'h7FFF_FFFF, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 32'h8000_0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h9FFF_FFFF, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'hA000_0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'hBFFF_FFFF, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'hC000_0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 32'h0000_1234, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h8000_0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b0, 32'hC000_0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        kernel_mode = 1'b0;
  logic [31:0] vaddr = '0;
  logic [3:0]  seg_sel;
  logic        legal, addr_err, cacheable, tlb_req, phys_valid;
  logic [28:0] phys_addr;
  logic [19:0] vpn;
  logic [11:0] page_off;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_seg_decoder i_vaddr_seg_decoder (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .kernel_mode(kernel_mode),
    .vaddr(vaddr), .seg_sel(seg_sel), .legal(legal), .addr_err(addr_err),
    .cacheable(cacheable), .tlb_req(tlb_req), .phys_valid(phys_valid),
    .phys_addr(phys_addr), .vpn(vpn), .page_off(page_off)
  );

  task automatic expect_out(input string req, input logic [31:0] a,
                            input logic [3:0] s, input logic e, input logic c,
                            input logic t, input logic p);
    logic [28:0] ephys;
    logic [19:0] evpn;
    logic [11:0] eoff;
    logic        elegal;
    ephys  = p ? a[28:0] : '0;
    evpn   = t ? a[31:12] : '0;
    eoff   = t ? a[11:0] : '0;
    elegal = (s != 4'b0);
    n_checks++;
    if (seg_sel !== s || addr_err !== e || cacheable !== c || tlb_req !== t ||
        phys_valid !== p || legal !== elegal || phys_addr !== ephys ||
        vpn !== evpn || page_off !== eoff) begin
      n_fail++;
      $display("FAIL %s addr=%h: got seg=%b err=%b c=%b t=%b pv=%b lg=%b pa=%h vpn=%h off=%h exp seg=%b err=%b c=%b t=%b pv=%b lg=%b pa=%h vpn=%h off=%h",
               req, a, seg_sel, addr_err, cacheable, tlb_req, phys_valid, legal,
               phys_addr, vpn, page_off, s, e, c, t, p, elegal, ephys, evpn, eoff);
    end
  endtask

  function automatic string req_of(input logic [VW-1:0] v);
    logic [31:0] a;
    a = v[39:8];
    if (!v[41]) return "R2";
    if (!a[31]) return "R3";
    if (!v[40]) return "R7";
    if (a[31:29] == 3'b100) return "R4";
    if (a[31:29] == 3'b101) return "R5";
    return "R6";
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    expect_out("R1", 32'h0, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // table walk: boundaries in both modes, invalid strobes (R2..R7, R9)
    for (int i = 0; i < NV; i++) begin
      acc_valid   = VEC[i][41];
      kernel_mode = VEC[i][40];
      vaddr       = VEC[i][39:8];
      @(negedge clk);
      expect_out(req_of(VEC[i]), VEC[i][39:8], VEC[i][7:4], VEC[i][3],
                 VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8: one-cycle latency; old result held until the next edge
    acc_valid = 1'b1; kernel_mode = 1'b1; vaddr = 32'h0040_5678;
    @(negedge clk);
    vaddr = 32'h8123_4567;
    #(CLK_PERIOD/4);
    expect_out("R8", 32'h0040_5678, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    expect_out("R8", 32'h8123_4567, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b1);

    // R7 vs region decode: user access into the kernel translated window
    kernel_mode = 1'b0; vaddr = 32'hE000_0ABC;
    @(negedge clk);
    expect_out("R7", 32'hE000_0ABC, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    kernel_mode = 1'b1;
    @(negedge clk);
    expect_out("R6", 32'hE000_0ABC, 4'b1000, 1'b0, 1'b0, 1'b1, 1'b0);

    // R5: uncached direct window, mid-window address
    vaddr = 32'hB5A5_A5A5;
    @(negedge clk);
    expect_out("R5", 32'hB5A5_A5A5, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1);

    // R1: reset wins over a valid kernel access
    rst = 1'b1; vaddr = 32'h8000_0010;
    @(negedge clk);
    expect_out("R1", 32'h0, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R4", 32'h8000_0010, 4'b0010, 1'b0, 1'b1, 1'b0, 1'b1);

    // R2: dropping the strobe clears a live result
    acc_valid = 1'b0;
    @(negedge clk);
    expect_out("R2", 32'h0, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule